// File: doc/BRIEF.md
# I2C Slave Address Match Responder

This block is the slave-side front end of an I2C peripheral. After reset, and again after every stop condition, it waits on the bus for a start condition. It then shifts in the first byte and compares bits 7..1 of that byte with a programmable seven-bit own address. On a match it pulls SDA low in the ninth clock, raises a flag that marks it as addressed, raises an interrupt flag, and records bit 0 of the byte as the transfer direction (1 = master reads, so the block transmits).

After the match the block moves one byte at a time, as a receiver or as a transmitter, under a local host. The host sees `irq`, `rx_data` and the status outputs. It answers with a single `host_go` pulse, which clears `irq` and, when the block is transmitting, loads `tx_data`. If the host has not answered by the falling edge of the ninth clock, the block holds SCL low until the pulse arrives. A mismatch, or a NACK from the master during a transmit, leaves the block passive until the next start or stop. A repeated start always returns it to the address phase.

Bus lines enter as sampled levels. Both outputs are open-drain enables, where 1 pulls the line low.

Top module: `i2c_addr_responder`

## Requirements
- R1: After reset `sda_oe`, `scl_oe`, `irq`, `addressed` and `master_nack` are 0.
- R2: When bits 7..1 of the byte after a start equal `own_addr`, `addressed` and `irq` go to 1 and `rw_bit` takes bit 0 of that byte. `irq` is never 1 while `addressed` is 0.
- R3: On an address match SDA is pulled low in the ninth clock, whatever the value of `ack_ctl`.
- R4: On an address mismatch SDA is never pulled and `irq` stays 0 until the next start or stop. This holds even if a later byte carries the own address.
- R5: If `irq` is still pending at the falling edge of the ninth SCL clock, `scl_oe` is 1 and stays 1 until `host_go`. A `host_go` in that same cycle prevents the hold.
- R6: As a receiver (`rw_bit` = 0), `rx_data` holds each data byte (first bit = MSB) when `irq` rises. The ninth-clock response on SDA equals `ack_ctl` (0 = ACK low, 1 = NACK released).
- R7: As a transmitter (`rw_bit` = 1), the byte loaded by `host_go` appears on SDA MSB first, one bit per SCL clock.
- R8: A NACK (SDA high in the ninth clock) from the master while transmitting sets `master_nack`. SDA and SCL are then released and no further bits are driven until the next start or stop.
- R9: A repeated start clears `addressed` and evaluates the following byte as a new address, including a new `rw_bit`.
- R10: A stop condition clears `addressed` and releases SDA and SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| own_addr | input | 7 | Seven-bit address the block answers to |
| ack_ctl | input | 1 | Data-byte response as receiver: 0 ACK, 1 NACK |
| tx_data | input | 8 | Byte to transmit, taken on `host_go` |
| host_go | input | 1 | Host handshake pulse: clear `irq`, load `tx_data`, end SCL hold |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 holds SCL low (clock stretch) |
| addressed | output | 1 | Addressed-as-slave flag |
| rw_bit | output | 1 | Direction bit captured from the address byte |
| irq | output | 1 | Byte or address event pending for the host |
| master_nack | output | 1 | Master answered the last transmitted byte with NACK |
| rx_data | output | 8 | Last received data byte |

## Verification
The ninth-clock falling edge and the host handshake can land in the same clock cycle. The edge then decides whether SCL is held, and the pulse both clears `irq` and supplies the next byte. The bench raises `host_go` on exactly the bench edge where it drops SCL after an acknowledge bit. It then expects no hold, a cleared `irq`, and an undisturbed next byte. A separate case lets the host answer late and expects SCL to stay held low across an idle wait.

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [6:0] own_addr,
  input  logic       ack_ctl,
  input  logic [7:0] tx_data,
  input  logic       host_go,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       addressed,
  output logic       rw_bit,
  output logic       irq,
  output logic       master_nack,
  output logic [7:0] rx_data
);
  typedef enum logic [2:0] {IDLE, ADDR, RXD, TXD, MUTE} st_t;
  st_t        st;
  logic       scl_q, sda_q;
  logic [7:0] sh;
  logic [3:0] bitn;

  wire scl_rise = ~scl_q & scl_in;
  wire scl_fall = scl_q & ~scl_in;
  wire start_c  = scl_q & scl_in & sda_q & ~sda_in;
  wire stop_c   = scl_q & scl_in & ~sda_q & sda_in;
  wire take     = host_go & irq;
  wire go       = host_go | ~irq;
  wire tx_next  = (st == TXD) | ((st == ADDR) & rw_bit);
  wire [7:0] nxt = host_go ? tx_data : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; scl_q <= 1'b1; sda_q <= 1'b1; sh <= '0; bitn <= '0;
      sda_oe <= 1'b0; scl_oe <= 1'b0; addressed <= 1'b0; rw_bit <= 1'b0;
      irq <= 1'b0; master_nack <= 1'b0; rx_data <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (take) begin
        irq <= 1'b0;
        if (tx_next) sh <= tx_data;
      end
      if (start_c || stop_c) begin
        st <= start_c ? ADDR : IDLE;
        bitn <= '0; sda_oe <= 1'b0; scl_oe <= 1'b0;
        addressed <= 1'b0; irq <= 1'b0; master_nack <= 1'b0;
      end else if (scl_oe) begin
        if (host_go) begin
          scl_oe <= 1'b0;
          if (st == TXD) sda_oe <= ~tx_data[7];
        end
      end else if (scl_rise) begin
        if (st == ADDR || st == RXD || st == TXD) begin
          bitn <= bitn + 4'd1;
          if (bitn < 4'd8 && st != TXD) sh <= {sh[6:0], sda_in};
          if (bitn == 4'd8 && st == TXD) master_nack <= sda_in;
        end
      end else if (scl_fall) begin
        case (st)
          ADDR: begin
            if (bitn == 4'd8) begin
              if (sh[7:1] == own_addr) begin
                addressed <= 1'b1; rw_bit <= sh[0]; irq <= 1'b1; sda_oe <= 1'b1;
              end else st <= MUTE;
            end else if (bitn == 4'd9) begin
              bitn <= '0;
              st <= rw_bit ? TXD : RXD;
              if (go) sda_oe <= rw_bit & ~nxt[7];
              else begin sda_oe <= 1'b0; scl_oe <= 1'b1; end
            end
          end
          RXD: begin
            if (bitn == 4'd8) begin
              rx_data <= sh; irq <= 1'b1; sda_oe <= ~ack_ctl;
            end else if (bitn == 4'd9) begin
              bitn <= '0; sda_oe <= 1'b0;
              if (!go) scl_oe <= 1'b1;
            end
          end
          TXD: begin
            if (bitn >= 4'd1 && bitn <= 4'd7) begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end else if (bitn == 4'd8) begin
              sda_oe <= 1'b0; irq <= 1'b1;
            end else if (bitn == 4'd9) begin
              bitn <= '0;
              if (master_nack) st <= MUTE;
              else if (go) sda_oe <= ~nxt[7];
              else scl_oe <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_addr_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic host_go,
  input logic sda_oe,
  input logic scl_oe,
  input logic addressed,
  input logic irq,
  input logic master_nack
);
  // R2
  irq_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> addressed);
  // R4
  sda_only_when_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n) sda_oe |-> addressed);
  // R5
  hold_until_host_chk: assert property (@(posedge clk) disable iff (!rst_n) (scl_oe && !host_go) |=> scl_oe);
  // R5
  hold_only_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n) scl_oe |-> addressed);
  // R8
  no_hold_after_nack_chk: assert property (@(posedge clk) disable iff (!rst_n) scl_oe |-> !master_nack);
endmodule

bind i2c_addr_responder i2c_addr_responder_chk u_chk (.*);

// File: tb/i2c_addr_responder_test.sv
module i2c_addr_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [6:0] own_addr = 7'h3A;
  logic ack_ctl = 0, host_go = 0;
  logic [7:0] tx_data = 0;
  logic sda_oe, scl_oe, addressed, rw_bit, irq, master_nack;
  logic [7:0] rx_data;
  wire scl_line = scl_m & ~scl_oe;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_responder uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .own_addr(own_addr), .ack_ctl(ack_ctl), .tx_data(tx_data), .host_go(host_go),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .addressed(addressed), .rw_bit(rw_bit),
    .irq(irq), .master_nack(master_nack), .rx_data(rx_data));

  function automatic logic exp_addr_ack(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_go(input logic [7:0] d);
    tx_data = d; host_go = 1; tick(1); host_go = 0; tick(1);
  endtask

  task automatic clock_bit(input logic b, output logic r, input logic go = 1'b0);
    sda_m = b; tick(H);
    scl_m = 1;
    do tick(1); while (!scl_line);
    tick(2); r = sda_line; tick(H - 2);
    scl_m = 0; host_go = go; tick(1); host_go = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, input logic go = 1'b0);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, ack, go);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, r); d[i] = r; end
    clock_bit(mack, r);
  endtask

  task automatic bus_start;
    sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
  endtask

  task automatic bus_stop;
    sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d, e, ab;
    void'($urandom(32'd4242));
    tick(3); rst_n = 1; tick(2);
    // R1 reset state
    chk("R1 sda_oe", sda_oe, 0); chk("R1 scl_oe", scl_oe, 0);
    chk("R1 irq", irq, 0); chk("R1 addressed", addressed, 0); chk("R1 master_nack", master_nack, 0);

    // R3 address ack forced even with ack_ctl = NACK
    ack_ctl = 1;
    bus_start; send_byte({7'h3A, 1'b0}, a);
    chk("R3 addr ack", a, 0);
    chk("R2 addressed", addressed, 1); chk("R2 rw_bit", rw_bit, 0); chk("R2 irq", irq, 1);
    tick(2); chk("R5 hold", scl_oe, 1);
    tick(20); chk("R5 hold kept", scl_oe, 1);
    pulse_go(8'h00); chk("R5 released", scl_oe, 0); chk("R5 irq cleared", irq, 0);

    // R6 receive, NACK then ACK; second byte uses same-cycle handshake
    d = 8'hA5; send_byte(d, a);
    chk("R6 nack", a, 1); chk("R6 data", rx_data, d); chk("R6 irq", irq, 1);
    pulse_go(8'h00);
    ack_ctl = 0; d = 8'h3C; send_byte(d, a, 1'b1);
    chk("R6 ack", a, 0); chk("R6 data", rx_data, d);
    tick(2); chk("R5 collision no hold", scl_oe, 0); chk("R5 collision irq", irq, 0);
    bus_stop; chk("R10 addressed cleared", addressed, 0); chk("R10 sda", sda_oe, 0);

    // R4 mismatch then ignored traffic
    bus_start; send_byte({7'h11, 1'b0}, a);
    chk("R4 no ack", a, 1); chk("R4 irq", irq, 0); chk("R4 addressed", addressed, 0);
    send_byte({7'h3A, 1'b0}, a);
    chk("R4 ignored own addr", a, 1); chk("R4 irq after", irq, 0);
    bus_stop;

    // R7 / R8 transmit with hold, then master NACK
    bus_start; send_byte({7'h3A, 1'b1}, a);
    chk("R3 addr ack rd", a, 0); chk("R2 rw_bit rd", rw_bit, 1);
    tick(2); chk("R5 hold rd", scl_oe, 1);
    e = 8'hC6; pulse_go(e);
    recv_byte(1'b0, d); chk("R7 tx byte", d, e);
    tick(2); chk("R5 hold after tx", scl_oe, 1);
    e = 8'h59; pulse_go(e);
    recv_byte(1'b1, d); chk("R7 tx byte2", d, e);
    tick(2); chk("R8 master_nack", master_nack, 1); chk("R8 scl free", scl_oe, 0);
    pulse_go(8'h00);
    recv_byte(1'b1, d); chk("R8 released", d, 8'hFF);
    bus_stop;

    // R9 repeated start changes direction
    bus_start; send_byte({7'h3A, 1'b0}, a); pulse_go(8'h00);
    send_byte(8'h12, a); pulse_go(8'h00);
    bus_start; chk("R9 cleared", addressed, 0);
    send_byte({7'h3A, 1'b1}, a);
    chk("R9 ack", a, 0); chk("R9 rw_bit", rw_bit, 1);
    e = 8'h81; pulse_go(e); recv_byte(1'b1, d); chk("R9 tx", d, e);
    pulse_go(8'h00);
    bus_start; send_byte({7'h22, 1'b0}, a);
    chk("R9 new mismatch", a, 1); chk("R9 addressed", addressed, 0);
    bus_stop;

    // constrained random transactions
    for (int k = 0; k < 8; k++) begin
      own_addr = 7'($urandom);
      ab = ($urandom % 3 == 0) ? 8'($urandom) : {own_addr, 1'($urandom)};
      bus_start; send_byte(ab, a);
      chk("R3 rnd ack", a, exp_addr_ack(ab, own_addr));
      if (!exp_addr_ack(ab, own_addr)) begin
        chk("R2 rnd rw", rw_bit, ab[0]);
        if (!ab[0]) begin
          for (int j = 0; j < 2; j++) begin
            ack_ctl = 1'($urandom); pulse_go(8'h00);
            d = 8'($urandom); send_byte(d, a);
            chk("R6 rnd data", rx_data, d); chk("R6 rnd ack", a, ack_ctl);
          end
          pulse_go(8'h00);
        end else begin
          e = 8'($urandom); pulse_go(e); recv_byte(1'b0, d); chk("R7 rnd tx", d, e);
          e = 8'($urandom); pulse_go(e); recv_byte(1'b1, d); chk("R7 rnd tx2", d, e);
          pulse_go(8'h00);
        end
      end else begin
        chk("R4 rnd irq", irq, 0);
      end
      bus_stop; chk("R10 rnd", addressed, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule